// File: doc/BRIEF.md
# Snoop Response Decision Unit

This unit sits beside one primary cache on a shared snooping bus and decides how that cache answers each bus cycle it observes. It is given the kind of bus cycle, the result of the cache's own lookup (hit flag, coherence state and transactional tag of the matching line), whether the cache is the transactional one, and whether the local transaction is still live. From these it returns the cache's reply, which is nothing, supplied data or a refusal (BUSY), and, when the line must change, its new coherence state.

The protocol is an invalidation snoop protocol with two added transactional cycles, a transactional read and a transactional read-for-ownership. A transactional cache that holds a live transaction's entries refuses these cycles, except a transactional read of a clean shared line. Entries that belong to an unfinished transaction are hidden from ordinary traffic. The replies of the other caches on the bus are also given to the unit, and it resolves which party answers the cycle: a refusal beats supplied data, and memory answers only when no cache does.

All outputs are registered. A cycle presented with `snoopValid` high is answered on the outputs after the next rising clock edge.

Top module: `snoop_resp_unit`

## Requirements
- R1: While `rstN` is low, and after it is released until the first snoop, `rspKind`, `stateWrEn` and `winner` are all 0.
- R2: A snoop whose `lookupHit` is 0, or whose line state is INVALID (0), or that reaches the transactional decision of R8/R9 with tag FREE (0), gives `rspKind` NONE (0) and `stateWrEn` 0.
- R3: In the regular cache (`isTransCache`=0), READ (0) or T_READ (3) hitting a VALID (1) line gives `rspKind` DATA (1) and `stateWrEn` 0.
- R4: In the regular cache, READ or T_READ hitting a DIRTY (2) or RESERVED (3) line gives DATA, `stateWrEn` 1 and `nextState` VALID (1).
- R5: In the regular cache, RFO (1) or T_RFO (4) hitting any non-INVALID line gives DATA, `stateWrEn` 1 and `nextState` INVALID (0).
- R6: In the transactional cache, when `txActive` is 0 or the cycle is READ or RFO, a line whose tag is not SETTLED (1) is treated as absent: `rspKind` NONE and `stateWrEn` 0.
- R7: In the transactional cache, under the conditions of R6, a line tagged SETTLED behaves exactly as in R3, R4 and R5.
- R8: In the transactional cache with `txActive` 1, T_READ hitting a VALID line whose tag is not FREE gives DATA and `stateWrEn` 0.
- R9: In the transactional cache with `txActive` 1, any other T_READ or T_RFO hit on a line whose tag is not FREE gives `rspKind` BUSY (2) and `stateWrEn` 0.
- R10: A WRITE (2) cycle never gives a reply or a state change, whatever the lookup.
- R11: `winner` combines the local reply with each 2-bit peer reply in `peerRsp` (peer g at bits 2g+1:2g, same coding as `rspKind`). It is BUSY (3) if any reply is BUSY, otherwise CACHE (1) if any reply is DATA, otherwise MEMORY (2).
- R12: Outputs follow the inputs with one cycle of latency. A cycle with `snoopValid` 0 gives `rspKind` NONE, `stateWrEn` 0 and `winner` NONE (0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snoopValid | input | 1 | A bus cycle is presented this clock |
| snoopCycle | input | 3 | Cycle kind: 0 READ, 1 RFO, 2 WRITE, 3 T_READ, 4 T_RFO |
| lookupHit | input | 1 | Local cache holds the line |
| lineState | input | 2 | Coherence state: 0 INVALID, 1 VALID, 2 DIRTY, 3 RESERVED |
| lineTag | input | 2 | Transactional tag: 0 FREE, 1 SETTLED, 2 OLDCOPY, 3 NEWCOPY |
| isTransCache | input | 1 | This unit serves the transactional cache |
| txActive | input | 1 | Local transaction status is live |
| peerRsp | input | 2*NUM_PEERS | Replies of the other caches to the same cycle |
| rspKind | output | 2 | Local reply: 0 NONE, 1 DATA, 2 BUSY |
| stateWrEn | output | 1 | Hit line's state must be rewritten |
| nextState | output | 2 | New line state, meaningful when stateWrEn is 1 |
| winner | output | 2 | Resolved responder: 0 NONE, 1 CACHE, 2 MEMORY, 3 BUSY |

## Verification
The decision is driven through every combination of cycle kind, line state, tag, cache kind, transaction status and hit flag with silent peers. This separates the regular demote and invalidate paths, the hiding of unsettled entries, and the refusal path of a live transaction. Directed cycles then set peer replies against the local reply: a silent local cache with a data-supplying peer, a supplying local cache against a refusing peer, and no responder at all. These tell the three priority levels apart. Idle clocks placed between snoops show that nothing leaks past the one-cycle latency.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  localparam logic [2:0] CYC_READ  = 3'd0;
  localparam logic [2:0] CYC_RFO   = 3'd1;
  localparam logic [2:0] CYC_WRITE = 3'd2;
  localparam logic [2:0] CYC_TREAD = 3'd3;
  localparam logic [2:0] CYC_TRFO  = 3'd4;

  localparam logic [1:0] ST_INVALID  = 2'd0;
  localparam logic [1:0] ST_VALID    = 2'd1;
  localparam logic [1:0] ST_DIRTY    = 2'd2;
  localparam logic [1:0] ST_RESERVED = 2'd3;

  localparam logic [1:0] TAG_FREE    = 2'd0;
  localparam logic [1:0] TAG_SETTLED = 2'd1;
  localparam logic [1:0] TAG_OLDCOPY = 2'd2;
  localparam logic [1:0] TAG_NEWCOPY = 2'd3;

  localparam logic [1:0] RSP_NONE = 2'd0;
  localparam logic [1:0] RSP_DATA = 2'd1;
  localparam logic [1:0] RSP_BUSY = 2'd2;

  localparam logic [1:0] WIN_NONE   = 2'd0;
  localparam logic [1:0] WIN_CACHE  = 2'd1;
  localparam logic [1:0] WIN_MEMORY = 2'd2;
  localparam logic [1:0] WIN_BUSY   = 2'd3;

  // strobes from the decision logic to the datapath
  typedef struct packed {
    logic supply;
    logic refuse;
    logic demote;
    logic invalidate;
  } snoopStrobe_t;

endpackage

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         snoopValid,
  input  logic [2:0]   snoopCycle,
  input  logic         lookupHit,
  input  logic [1:0]   lineState,
  input  logic [1:0]   lineTag,
  input  logic         isTransCache,
  input  logic         txActive,
  output snoopStrobe_t strb
);

  logic readKind;
  logic ownKind;
  logic txKind;
  logic present;
  logic txPath;

  assign readKind = (snoopCycle == CYC_READ) || (snoopCycle == CYC_TREAD);
  assign ownKind  = (snoopCycle == CYC_RFO)  || (snoopCycle == CYC_TRFO);
  assign txKind   = (snoopCycle == CYC_TREAD) || (snoopCycle == CYC_TRFO);
  assign present  = lookupHit && (lineState != ST_INVALID);
  assign txPath   = isTransCache && txActive && txKind;

  always_comb begin
    strb = '0;
    if (snoopValid && present && (readKind || ownKind)) begin
      if (txPath) begin
        if (lineTag != TAG_FREE) begin
          if ((snoopCycle == CYC_TREAD) && (lineState == ST_VALID)) strb.supply = 1'b1;
          else                                                      strb.refuse = 1'b1;
        end
      end else if (!isTransCache || (lineTag == TAG_SETTLED)) begin
        strb.supply = 1'b1;
        if (ownKind)                                                    strb.invalidate = 1'b1;
        else if ((lineState == ST_DIRTY) || (lineState == ST_RESERVED)) strb.demote     = 1'b1;
      end
    end
  end

  // R9
  refuse_scope_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.refuse |-> (isTransCache && txActive && txKind));

endmodule

// File: rtl/snoop_dp.sv
module snoop_dp
  import snoop_pkg::*;
#(
  parameter int NUM_PEERS = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  snoopStrobe_t           strb,
  input  logic                   snoopValid,
  input  logic [1:0]             lineState,
  input  logic [2*NUM_PEERS-1:0] peerRsp,
  output logic [1:0]             rspKind,
  output logic                   stateWrEn,
  output logic [1:0]             nextState,
  output logic [1:0]             winner
);

  localparam int NUM_SRC = NUM_PEERS + 1;

  logic [1:0]         localRsp;
  logic [NUM_SRC-1:0] srcBusy;
  logic [NUM_SRC-1:0] srcData;
  logic [1:0]         winComb;
  logic [1:0]         nxtComb;

  assign localRsp = strb.refuse ? RSP_BUSY : (strb.supply ? RSP_DATA : RSP_NONE);
  assign srcBusy[0] = (localRsp == RSP_BUSY);
  assign srcData[0] = (localRsp == RSP_DATA);

  for (genvar g = 0; g < NUM_PEERS; g++) begin : g_peer
    assign srcBusy[g+1] = (peerRsp[2*g +: 2] == RSP_BUSY);
    assign srcData[g+1] = (peerRsp[2*g +: 2] == RSP_DATA);
  end

  always_comb begin
    if (!snoopValid)    winComb = WIN_NONE;
    else if (|srcBusy)  winComb = WIN_BUSY;
    else if (|srcData)  winComb = WIN_CACHE;
    else                winComb = WIN_MEMORY;
  end

  assign nxtComb = strb.invalidate ? ST_INVALID : (strb.demote ? ST_VALID : lineState);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspKind   <= RSP_NONE;
      stateWrEn <= 1'b0;
      nextState <= ST_INVALID;
      winner    <= WIN_NONE;
    end else begin
      rspKind   <= localRsp;
      stateWrEn <= strb.invalidate | strb.demote;
      nextState <= nxtComb;
      winner    <= winComb;
    end
  end

  // R9
  busy_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspKind == RSP_BUSY) |-> !stateWrEn);

endmodule

// File: rtl/snoop_resp_unit.sv
module snoop_resp_unit
  import snoop_pkg::*;
#(
  parameter int NUM_PEERS = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   snoopValid,
  input  logic [2:0]             snoopCycle,
  input  logic                   lookupHit,
  input  logic [1:0]             lineState,
  input  logic [1:0]             lineTag,
  input  logic                   isTransCache,
  input  logic                   txActive,
  input  logic [2*NUM_PEERS-1:0] peerRsp,
  output logic [1:0]             rspKind,
  output logic                   stateWrEn,
  output logic [1:0]             nextState,
  output logic [1:0]             winner
);

  snoopStrobe_t strb;

  snoop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .snoopValid(snoopValid), .snoopCycle(snoopCycle),
    .lookupHit(lookupHit), .lineState(lineState), .lineTag(lineTag),
    .isTransCache(isTransCache), .txActive(txActive), .strb(strb)
  );

  snoop_dp #(.NUM_PEERS(NUM_PEERS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .snoopValid(snoopValid),
    .lineState(lineState), .peerRsp(peerRsp), .rspKind(rspKind),
    .stateWrEn(stateWrEn), .nextState(nextState), .winner(winner)
  );

  // R10
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && (snoopCycle == CYC_WRITE)) |=> ((rspKind == RSP_NONE) && !stateWrEn));

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && !lookupHit) |=> ((rspKind == RSP_NONE) && !stateWrEn));

  // R11
  busy_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspKind == RSP_BUSY) |-> (winner == WIN_BUSY));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !snoopValid |=> ((winner == WIN_NONE) && (rspKind == RSP_NONE)));

  // R5
  inval_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateWrEn && (nextState == ST_INVALID)) |->
      (($past(snoopCycle) == CYC_RFO) || ($past(snoopCycle) == CYC_TRFO)));

endmodule

// File: tb/tb_snoop_resp_unit.sv
module tb_snoop_resp_unit;
  import snoop_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          snoopValid = 1'b0;
  logic [2:0]    snoopCycle = '0;
  logic          lookupHit = 1'b0;
  logic [1:0]    lineState = '0;
  logic [1:0]    lineTag = '0;
  logic          isTransCache = 1'b0;
  logic          txActive = 1'b0;
  logic [2*NP-1:0] peerRsp = '0;
  logic [1:0]    rspKind;
  logic          stateWrEn;
  logic [1:0]    nextState;
  logic [1:0]    winner;

  typedef struct {
    logic [1:0] rsp;
    logic       wr;
    logic [1:0] nxt;
    logic [1:0] win;
    string      req;
  } exp_t;

  exp_t sb[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  snoop_resp_unit #(.NUM_PEERS(NP)) dut (
    .clk(clk), .rstN(rstN), .snoopValid(snoopValid), .snoopCycle(snoopCycle),
    .lookupHit(lookupHit), .lineState(lineState), .lineTag(lineTag),
    .isTransCache(isTransCache), .txActive(txActive), .peerRsp(peerRsp),
    .rspKind(rspKind), .stateWrEn(stateWrEn), .nextState(nextState), .winner(winner)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected reply from the requirement table
  function automatic exp_t model(logic v, logic [2:0] c, logic h, logic [1:0] s,
                                 logic [1:0] t, logic tr, logic tx, logic [2*NP-1:0] p);
    exp_t e;
    logic rd, own, txc, anyBusy, anyData;
    e.rsp = 2'd0; e.wr = 1'b0; e.nxt = s; e.req = "";
    rd  = (c == 3'd0) || (c == 3'd3);
    own = (c == 3'd1) || (c == 3'd4);
    txc = (c == 3'd3) || (c == 3'd4);
    if (v && h && (s != 2'd0) && (rd || own)) begin
      if (tr && tx && txc) begin
        if (t != 2'd0) e.rsp = ((c == 3'd3) && (s == 2'd1)) ? 2'd1 : 2'd2;
      end else if (!tr || (t == 2'd1)) begin
        e.rsp = 2'd1;
        if (own) begin e.wr = 1'b1; e.nxt = 2'd0; end
        else if (s >= 2'd2) begin e.wr = 1'b1; e.nxt = 2'd1; end
      end
    end
    anyBusy = (e.rsp == 2'd2);
    anyData = (e.rsp == 2'd1);
    for (int g = 0; g < NP; g++) begin
      if (p[2*g +: 2] == 2'd2) anyBusy = 1'b1;
      if (p[2*g +: 2] == 2'd1) anyData = 1'b1;
    end
    e.win = !v ? 2'd0 : (anyBusy ? 2'd3 : (anyData ? 2'd1 : 2'd2));
    return e;
  endfunction

  function automatic string classify(logic [2:0] c, logic h, logic [1:0] s,
                                     logic [1:0] t, logic tr, logic tx);
    logic txc;
    txc = (c == 3'd3) || (c == 3'd4);
    if (c == 3'd2) return "R10";
    if (!h || s == 2'd0) return "R2";
    if (tr && tx && txc) begin
      if (t == 2'd0) return "R2";
      return ((c == 3'd3) && (s == 2'd1)) ? "R8" : "R9";
    end
    if (tr && t != 2'd1) return "R6";
    if (tr) return "R7";
    if (c == 3'd1 || c == 3'd4) return "R5";
    return (s == 2'd1) ? "R3" : "R4";
  endfunction

  // driver: present one cycle and queue what it must produce
  task automatic apply(input logic v, input logic [2:0] c, input logic h,
                       input logic [1:0] s, input logic [1:0] t, input logic tr,
                       input logic tx, input logic [2*NP-1:0] p, input string req);
    exp_t e;
    @(negedge clk);
    snoopValid = v; snoopCycle = c; lookupHit = h; lineState = s;
    lineTag = t; isTransCache = tr; txActive = tx; peerRsp = p;
    e = model(v, c, h, s, t, tr, tx, p);
    e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compare registered outputs shortly after each edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (rstN && sb.size() > 0) begin
      e = sb.pop_front();
      total++;
      if (rspKind !== e.rsp || stateWrEn !== e.wr || winner !== e.win ||
          (e.wr && nextState !== e.nxt)) begin
        bad++;
        $display("FAIL %s: actual rsp=%0d wr=%0d nxt=%0d win=%0d expected rsp=%0d wr=%0d nxt=%0d win=%0d",
                 e.req, rspKind, stateWrEn, nextState, winner, e.rsp, e.wr, e.nxt, e.win);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R12: watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    total++;
    // R1 reset state
    if (rspKind !== 2'd0 || stateWrEn !== 1'b0 || winner !== 2'd0) begin
      bad++;
      $display("FAIL R1: actual rsp=%0d wr=%0d win=%0d expected 0 0 0", rspKind, stateWrEn, winner);
    end
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    total++;
    if (rspKind !== 2'd0 || stateWrEn !== 1'b0 || winner !== 2'd0) begin
      bad++;
      $display("FAIL R1: after release actual rsp=%0d wr=%0d win=%0d expected 0 0 0", rspKind, stateWrEn, winner);
    end

    // exhaustive sweep with silent peers (R2..R10)
    for (int c = 0; c < 5; c++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 4; t++)
          for (int k = 0; k < 8; k++)
            apply(1'b1, 3'(c), k[0], 2'(s), 2'(t), k[1], k[2], '0,
                  classify(3'(c), k[0], 2'(s), 2'(t), k[1], k[2]));

    // R11 priority with peers
    apply(1'b1, CYC_READ, 1'b0, ST_VALID, TAG_SETTLED, 1'b0, 1'b0, {RSP_NONE, RSP_DATA}, "R11 peer data");
    apply(1'b1, CYC_READ, 1'b1, ST_DIRTY, TAG_SETTLED, 1'b0, 1'b0, {RSP_BUSY, RSP_NONE}, "R11 peer busy beats local data");
    apply(1'b1, CYC_TRFO, 1'b1, ST_VALID, TAG_NEWCOPY, 1'b1, 1'b1, {RSP_DATA, RSP_DATA}, "R11 local busy beats peer data");
    apply(1'b1, CYC_RFO, 1'b0, ST_VALID, TAG_SETTLED, 1'b0, 1'b0, {RSP_NONE, RSP_NONE}, "R11 memory answers");
    apply(1'b1, CYC_WRITE, 1'b1, ST_DIRTY, TAG_SETTLED, 1'b0, 1'b0, {RSP_NONE, RSP_NONE}, "R10 write to memory");

    // R12 idle cycles between snoops, even with peer noise
    apply(1'b0, CYC_READ, 1'b1, ST_DIRTY, TAG_SETTLED, 1'b0, 1'b0, {RSP_BUSY, RSP_DATA}, "R12 idle");
    apply(1'b1, CYC_TREAD, 1'b1, ST_RESERVED, TAG_SETTLED, 1'b0, 1'b0, '0, "R4 after idle");
    apply(1'b0, CYC_RFO, 1'b1, ST_VALID, TAG_SETTLED, 1'b0, 1'b0, '0, "R12 idle");
    apply(1'b1, CYC_TREAD, 1'b1, ST_VALID, TAG_OLDCOPY, 1'b1, 1'b1, '0, "R8 after idle");
    apply(1'b0, CYC_READ, 1'b0, ST_INVALID, TAG_FREE, 1'b0, 1'b0, '0, "R12 idle");

    @(negedge clk);
    snoopValid = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule